// File: doc/BRIEF.md
# Vertical Six-Tap Half-Sample Interpolator (4x4 luma)

This block produces the vertical half-sample luma values of a 4x4 block of 8-bit pixels. A producer streams source rows into it, four packed pixels per beat. A block needs nine rows: two rows of margin above the 4x4 area, the four rows of the area itself, and three rows below. Output row k is the half-sample row that lies between source rows k+2 and k+3. Each pixel is a six-tap filter taken down its own column, rounded, scaled by 1/32 and clipped to 0..255.

Internally the nine rows sit in a small register file. The output rows are computed two at a time, as soon as the rows that the pair needs are present. Four column datapaths run side by side for each of the two rows. Each datapath adds a fixed offset to every pixel so that its sums are never negative. A saturating subtract then removes that offset and adds the rounding term in a single operation, and a 13-bit saturation, a 5-bit shift and a byte mask finish the clip. Both sides use a valid/ready handshake, and the consumer receives the four rows in order. After the fourth row is taken, the block is ready for the next block's first row.

Top module: `vhalf_interp4x4`

## Requirements
- R1: Each output pixel equals clip(((A+F) + 20*(C+D) - 5*(B+E) + 16) >> 5) to the range 0..255. A..F are six vertically consecutive source pixels of the same column, and the half-sample position lies between C and D.
- R2: Pixel column j (0..3) occupies bits [8j+7:8j] of both `src_row` and `dst_row`, so column 0 is the least significant byte.
- R3: Source rows are numbered 0..8 in the order they are accepted. Output row k (0..3) uses source rows k..k+5 as A..F.
- R4: If the seventh source row of a block is accepted at clock edge n, `dst_valid` is high after edge n+1 and low after edge n.
- R5: `src_ready` goes low on the edge that accepts the ninth row. It stays low until the fourth output row is accepted. Beats offered while `src_ready` is low are ignored and affect no output.
- R6: While `dst_valid` is high and `dst_ready` is low, `dst_valid` stays high and `dst_row` holds its value.
- R7: Output rows leave in order 0, 1, 2, 3. In the cycle after the fourth row is accepted, `dst_valid` is low and `src_ready` is high, and the next accepted beat becomes row 0 of a new block.
- R8: While `rst` is high on a clock edge, all counters and valid flags clear. After reset, `src_ready` is 1 and `dst_valid` is 0.
- R9: Results above 255 give 255 and results below zero give 0. All-255 input gives 255 and all-zero input gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| src_valid | input | 1 | Source row offered |
| src_ready | output | 1 | Block can take a source row |
| src_row | input | 32 | Four packed source pixels |
| dst_valid | output | 1 | Output row available |
| dst_ready | input | 1 | Consumer takes the output row |
| dst_row | output | 32 | Four packed interpolated pixels |

## Verification
The first output row is due exactly one idle cycle after the seventh source row is accepted. The bench checks that `dst_valid` is still low half a cycle after that acceptance edge and high one cycle later. The later rows of a pair follow on each accepted beat. The second pair needs the ninth row and an empty hold register, so the bench waits for `dst_valid` with a bounded count instead of assuming a fixed gap. `src_ready` is sampled at the falling edge right after the ninth acceptance and right after the fourth output acceptance, the two cycles in which R5 and R7 place its changes. All inputs change at falling edges or shortly after a rising edge, and all outputs are read at falling edges.

// File: rtl/vhi_pkg.sv
package vhi_pkg;

   // Width of a counter able to hold values 0..n
   function automatic int cnt_w(input int n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

   // Width of an index over n entries, never zero
   function automatic int idx_w(input int n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/vhi_rowbuf.sv
module vhi_rowbuf #(
   parameter int ROW_W = 32,
   parameter int ROWS  = 9,
   parameter int WIN   = 7,
   parameter int CW    = 4
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      wr_en,
   input  logic [CW-1:0]             wr_idx,
   input  logic [ROW_W-1:0]          wr_data,
   input  logic [CW-1:0]             rd_base,
   output logic [WIN-1:0][ROW_W-1:0] win
);

   logic [ROWS-1:0][ROW_W-1:0] mem_q;

   if (WIN > ROWS) begin : g_bad_win
      $error("vhi_rowbuf: window larger than storage");
   end

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      always_ff @(posedge clk) begin
         if (rst) begin
            mem_q[r] <= '0;
         end else if (wr_en && (wr_idx == CW'(r))) begin
            mem_q[r] <= wr_data;
         end
      end
   end

   for (genvar i = 0; i < WIN; i++) begin : g_win
      logic [CW:0] rd_idx;
      assign rd_idx = {1'b0, rd_base} + (CW+1)'(i);
      always_comb begin
         win[i] = '0;
         for (int r = 0; r < ROWS; r++) begin
            if (rd_idx == (CW+1)'(r)) begin
               win[i] = mem_q[r];
            end
         end
      end
   end

endmodule

// File: rtl/vhi_clip.sv
module vhi_clip #(
   parameter int PIX_W  = 8,
   parameter int ACC_W  = 16,
   parameter int SHIFT  = 5,
   parameter int OFFSET = 4064
) (
   input  logic [ACC_W-1:0] acc,
   output logic [PIX_W-1:0] pix
);

   localparam int SAT_W = PIX_W + SHIFT;
   localparam logic [ACC_W-1:0] OFF_V = ACC_W'(OFFSET);
   localparam logic [ACC_W-1:0] SAT_MAX = ACC_W'((1 << SAT_W) - 1);

   if (SAT_W > ACC_W) begin : g_bad_sat
      $error("vhi_clip: saturation width exceeds accumulator");
   end

   logic [ACC_W-1:0] unbiased;
   logic [ACC_W-1:0] saturated;
   logic [ACC_W-1:0] scaled;

   // unsigned subtract with a floor at zero
   assign unbiased  = (acc > OFF_V) ? (acc - OFF_V) : '0;
   // ceiling at SAT_W unsigned bits
   assign saturated = (unbiased > SAT_MAX) ? SAT_MAX : unbiased;
   assign scaled    = saturated >> SHIFT;
   assign pix       = PIX_W'(scaled);

endmodule

// File: rtl/vhi_lane.sv
module vhi_lane #(
   parameter int PIX_W  = 8,
   parameter int ACC_W  = 16,
   parameter int SHIFT  = 5,
   parameter int BIAS   = 255,
   parameter bit BIASED = 1'b1
) (
   input  logic [PIX_W-1:0] t0,
   input  logic [PIX_W-1:0] t1,
   input  logic [PIX_W-1:0] t2,
   input  logic [PIX_W-1:0] t3,
   input  logic [PIX_W-1:0] t4,
   input  logic [PIX_W-1:0] t5,
   output logic [PIX_W-1:0] pix
);

   localparam int PMAX   = (1 << PIX_W) - 1;
   localparam int ROUND  = 1 << (SHIFT - 1);
   localparam int ACC_LO = 16 * BIAS - 10 * PMAX;
   localparam int ACC_HI = 16 * BIAS + 42 * PMAX;

   if (BIASED) begin : g_biased
      if (ACC_LO < 0 || ACC_HI >= (1 << ACC_W)) begin : g_bad_range
         $error("vhi_lane: bias or width does not keep sums in range");
      end

      logic [ACC_W-1:0] near_sum;   // bias + two inner taps
      logic [ACC_W-1:0] mid_sum;    // bias + two middle taps
      logic [ACC_W-1:0] far_sum;    // bias + two outer taps
      logic [ACC_W-1:0] diff4;
      logic [ACC_W-1:0] diff20;
      logic [ACC_W-1:0] acc;

      assign near_sum = ACC_W'(BIAS) + ACC_W'(t2) + ACC_W'(t3);
      assign mid_sum  = ACC_W'(BIAS) + ACC_W'(t1) + ACC_W'(t4);
      assign far_sum  = ACC_W'(BIAS) + ACC_W'(t0) + ACC_W'(t5);
      assign diff4    = (near_sum << 2) - mid_sum;
      assign diff20   = diff4 + (diff4 << 2);
      assign acc      = diff20 + far_sum;

      // R1: the biased accumulator stays inside the window the bias promises
      always_comb begin
         p_acc_range_r1: assert (acc >= ACC_W'(ACC_LO) && acc <= ACC_W'(ACC_HI))
            else $error("biased accumulator left its range");
      end

      vhi_clip #(
         .PIX_W (PIX_W),
         .ACC_W (ACC_W),
         .SHIFT (SHIFT),
         .OFFSET(16 * BIAS - ROUND)
      ) u_clip (
         .acc(acc),
         .pix(pix)
      );
   end else begin : g_signed
      int raw;
      int scaled;
      always_comb begin
         raw = int'(t0) + int'(t5) + 20 * (int'(t2) + int'(t3))
             - 5 * (int'(t1) + int'(t4)) + ROUND;
         scaled = raw >>> SHIFT;
         if (scaled < 0) begin
            pix = '0;
         end else if (scaled > PMAX) begin
            pix = PIX_W'(PMAX);
         end else begin
            pix = PIX_W'(scaled);
         end
      end
   end

endmodule

// File: rtl/vhalf_interp4x4.sv
module vhalf_interp4x4 #(
   parameter int PIX_W  = 8,
   parameter int LANES  = 4,
   parameter int OROWS  = 4,
   parameter int TAPS   = 6,
   parameter int RPS    = 2,
   parameter int BIAS   = 255,
   parameter int ACC_W  = 16,
   parameter int SHIFT  = 5,
   parameter bit BIASED = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     src_valid,
   output logic                     src_ready,
   input  logic [PIX_W*LANES-1:0]   src_row,
   output logic                     dst_valid,
   input  logic                     dst_ready,
   output logic [PIX_W*LANES-1:0]   dst_row
);
   import vhi_pkg::*;

   localparam int ROW_W = PIX_W * LANES;
   localparam int IROWS = OROWS + TAPS - 1;
   localparam int WIN   = RPS + TAPS - 1;
   localparam int STEPS = OROWS / RPS;
   localparam int CW    = cnt_w(IROWS);
   localparam int SLW   = idx_w(RPS);
   localparam int STW   = idx_w(STEPS);

   if (TAPS != 6) begin : g_bad_taps
      $error("vhalf_interp4x4: the filter has exactly six taps");
   end
   if (OROWS % RPS != 0) begin : g_bad_step
      $error("vhalf_interp4x4: output rows must split evenly into steps");
   end
   if (SHIFT < 1) begin : g_bad_shift
      $error("vhalf_interp4x4: shift must be at least one");
   end

   logic [CW-1:0]              wr_cnt_q;
   logic [STW-1:0]             step_q;
   logic [SLW-1:0]             sel_q;
   logic                       held_q;
   logic [RPS-1:0][ROW_W-1:0]  hold_q;
   logic [RPS-1:0][ROW_W-1:0]  calc;
   logic [WIN-1:0][ROW_W-1:0]  win;
   logic [CW-1:0]              rd_base;
   logic [CW-1:0]              need_cnt;
   logic                       load;
   logic                       src_fire;
   logic                       dst_fire;
   logic                       last_in_step;
   logic                       last_step;

   assign src_ready    = (wr_cnt_q < CW'(IROWS));
   assign src_fire     = src_valid && src_ready;
   assign dst_valid    = held_q;
   assign dst_fire     = held_q && dst_ready;
   assign dst_row      = hold_q[sel_q];
   assign rd_base      = CW'(int'(step_q) * RPS);
   assign need_cnt     = CW'((int'(step_q) + 1) * RPS + TAPS - 1);
   assign load         = !held_q && (wr_cnt_q >= need_cnt);
   assign last_in_step = (sel_q == SLW'(RPS - 1));
   assign last_step    = (step_q == STW'(STEPS - 1));

   vhi_rowbuf #(
      .ROW_W(ROW_W),
      .ROWS (IROWS),
      .WIN  (WIN),
      .CW   (CW)
   ) u_rowbuf (
      .clk    (clk),
      .rst    (rst),
      .wr_en  (src_fire),
      .wr_idx (wr_cnt_q),
      .wr_data(src_row),
      .rd_base(rd_base),
      .win    (win)
   );

   for (genvar r = 0; r < RPS; r++) begin : g_out
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         vhi_lane #(
            .PIX_W (PIX_W),
            .ACC_W (ACC_W),
            .SHIFT (SHIFT),
            .BIAS  (BIAS),
            .BIASED(BIASED)
         ) u_lane (
            .t0 (win[r + 0][l*PIX_W +: PIX_W]),
            .t1 (win[r + 1][l*PIX_W +: PIX_W]),
            .t2 (win[r + 2][l*PIX_W +: PIX_W]),
            .t3 (win[r + 3][l*PIX_W +: PIX_W]),
            .t4 (win[r + 4][l*PIX_W +: PIX_W]),
            .t5 (win[r + 5][l*PIX_W +: PIX_W]),
            .pix(calc[r][l*PIX_W +: PIX_W])
         );
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_cnt_q <= '0;
         step_q   <= '0;
         sel_q    <= '0;
         held_q   <= 1'b0;
         hold_q   <= '0;
      end else begin
         if (src_fire) begin
            wr_cnt_q <= wr_cnt_q + CW'(1);
         end
         if (load) begin
            held_q <= 1'b1;
            hold_q <= calc;
         end
         if (dst_fire) begin
            if (last_in_step) begin
               held_q <= 1'b0;
               sel_q  <= '0;
               if (last_step) begin
                  step_q   <= '0;
                  wr_cnt_q <= '0;
               end else begin
                  step_q <= step_q + STW'(1);
               end
            end else begin
               sel_q <= sel_q + SLW'(1);
            end
         end
      end
   end

   // R3: no output is offered before the first step's rows are stored
   p_window_r3: assert property (@(posedge clk) disable iff (rst)
      dst_valid |-> (wr_cnt_q >= CW'(WIN)));

   // R4: one idle cycle between the seventh accepted row and the first output
   p_latency_r4: assert property (@(posedge clk) disable iff (rst)
      (src_fire && wr_cnt_q == CW'(WIN - 1) && step_q == '0 && !held_q)
      |-> ##2 dst_valid);

   // R5: accepting the last source row closes the input side
   p_full_stall_r5: assert property (@(posedge clk) disable iff (rst)
      (src_fire && wr_cnt_q == CW'(IROWS - 1)) |=> !src_ready);

   // R6: a stalled output holds still
   p_hold_r6: assert property (@(posedge clk) disable iff (rst)
      (dst_valid && !dst_ready) |=> (dst_valid && $stable(dst_row)));

   // R7: taking the last output row returns the block to idle
   p_done_r7: assert property (@(posedge clk) disable iff (rst)
      (dst_fire && last_in_step && last_step) |=> (!dst_valid && src_ready));

   // R8: leaving reset finds an empty, ready block
   p_reset_r8: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (src_ready && !dst_valid));

endmodule

// File: tb/vhalf_interp4x4_tb_top.sv
module vhalf_interp4x4_tb_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        src_valid = 1'b0;
   logic        src_ready;
   logic [31:0] src_row = '0;
   logic        dst_valid;
   logic        dst_ready = 1'b0;
   logic [31:0] dst_row;

   int vectors = 0;
   int miscompares = 0;
   logic [31:0] blk [9];

   always #2.5 clk = ~clk;   // 200 MHz

   vhalf_interp4x4 dut_i (
      .clk      (clk),
      .rst      (rst),
      .src_valid(src_valid),
      .src_ready(src_ready),
      .src_row  (src_row),
      .dst_valid(dst_valid),
      .dst_ready(dst_ready),
      .dst_row  (dst_row)
   );

   function automatic logic [7:0] ref_pix(int a, int b, int c, int d, int e, int f);
      int v;
      v = a + f + 20 * (c + d) - 5 * (b + e) + 16;
      if (v < 0) v = 0;
      v = v >>> 5;
      if (v > 255) v = 255;
      return v[7:0];
   endfunction

   // R2, R3: row k takes source rows k..k+5, byte j is column j
   function automatic logic [31:0] exp_row(int k);
      logic [31:0] r;
      for (int j = 0; j < 4; j++) begin
         r[8*j +: 8] = ref_pix(int'(blk[k][8*j +: 8]),   int'(blk[k+1][8*j +: 8]),
                               int'(blk[k+2][8*j +: 8]), int'(blk[k+3][8*j +: 8]),
                               int'(blk[k+4][8*j +: 8]), int'(blk[k+5][8*j +: 8]));
      end
      return r;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic push(input logic [31:0] r);
      int w = 0;
      @(negedge clk);
      src_valid = 1'b1;
      src_row   = r;
      while (!src_ready && w < 64) begin
         @(negedge clk);
         w++;
      end
      if (!src_ready) chk(1'b0, "R5", "input never ready", 32'h0, 32'h1);
      @(posedge clk);
      #1 src_valid = 1'b0;
   endtask

   task automatic push_rows(input int from, input int to);
      for (int i = from; i <= to; i++) push(blk[i]);
   endtask

   task automatic pop_check(input int k, input int stall, input string req);
      int w = 0;
      logic [31:0] got;
      @(negedge clk);
      dst_ready = 1'b0;
      while (!dst_valid && w < 64) begin
         @(negedge clk);
         w++;
      end
      if (!dst_valid) begin
         chk(1'b0, req, "output row never valid", 32'h0, 32'h1);
         return;
      end
      got = dst_row;
      for (int s = 0; s < stall; s++) begin
         @(negedge clk);
         chk(dst_valid && dst_row == got, "R6", "stalled row changed", dst_row, got);
      end
      chk(got == exp_row(k), req, $sformatf("row %0d value", k), got, exp_row(k));
      dst_ready = 1'b1;
      @(posedge clk);
   endtask

   task automatic drain(input string req);
      for (int k = 0; k < 4; k++) pop_check(k, 0, req);
      @(negedge clk);
      dst_ready = 1'b0;
   endtask

   task automatic fill_ramp(input int seed);
      for (int i = 0; i < 9; i++)
         for (int j = 0; j < 4; j++)
            blk[i][8*j +: 8] = 8'((seed + i * 29 + j * 71 + i * j * 13) & 255);
   endtask

   task automatic fill_const(input logic [7:0] v);
      for (int i = 0; i < 9; i++) blk[i] = {4{v}};
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk(src_ready == 1'b1, "R8", "src_ready after reset", 32'(src_ready), 32'h1);
      chk(dst_valid == 1'b0, "R8", "dst_valid after reset", 32'(dst_valid), 32'h0);
   endtask

   task automatic t_ramp;   // R1 R2 R3
      fill_ramp(3);
      push_rows(0, 8);
      drain("R1");
      fill_ramp(140);
      push_rows(0, 8);
      drain("R3");
   endtask

   task automatic t_extremes;   // R9
      fill_const(8'h00);
      push_rows(0, 8);
      drain("R9");
      fill_const(8'hff);
      push_rows(0, 8);
      drain("R9");
      // row pairs and columns alternate 0/255: drives both clip limits
      for (int i = 0; i < 9; i++)
         for (int j = 0; j < 4; j++)
            blk[i][8*j +: 8] = (((i / 2) + j) % 2 != 0) ? 8'hff : 8'h00;
      chk(exp_row(0)[7:0] == 8'hff && exp_row(2)[7:0] == 8'h00, "R9",
          "pattern reaches both limits", exp_row(0), exp_row(2));
      push_rows(0, 8);
      drain("R9");
   endtask

   task automatic t_latency;   // R4
      fill_ramp(77);
      push_rows(0, 6);
      @(negedge clk);
      chk(dst_valid == 1'b0, "R4", "dst_valid one edge early", 32'(dst_valid), 32'h0);
      @(negedge clk);
      chk(dst_valid == 1'b1, "R4", "dst_valid at due edge", 32'(dst_valid), 32'h1);
      push_rows(7, 8);
      drain("R4");
   endtask

   task automatic t_full_ignore;   // R5
      fill_ramp(201);
      push_rows(0, 8);
      @(negedge clk);
      chk(src_ready == 1'b0, "R5", "src_ready after ninth row", 32'(src_ready), 32'h0);
      src_valid = 1'b1;
      src_row   = 32'hdeadbeef;
      repeat (4) @(negedge clk);
      chk(src_ready == 1'b0, "R5", "src_ready while full", 32'(src_ready), 32'h0);
      src_valid = 1'b0;
      drain("R5");
   endtask

   task automatic t_backpressure;   // R6
      fill_ramp(55);
      push_rows(0, 8);
      pop_check(0, 3, "R6");
      pop_check(1, 1, "R6");
      pop_check(2, 4, "R6");
      pop_check(3, 2, "R6");
      @(negedge clk);
      dst_ready = 1'b0;
   endtask

   task automatic t_back_to_back;   // R7
      fill_ramp(9);
      push_rows(0, 8);
      for (int k = 0; k < 4; k++) pop_check(k, 0, "R7");
      @(negedge clk);
      dst_ready = 1'b0;
      chk(src_ready == 1'b1, "R7", "src_ready after last row", 32'(src_ready), 32'h1);
      chk(dst_valid == 1'b0, "R7", "dst_valid after last row", 32'(dst_valid), 32'h0);
      fill_ramp(188);
      push_rows(0, 8);
      drain("R7");
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_ramp();
      t_extremes();
      t_latency();
      t_full_ignore();
      t_backpressure();
      t_back_to_back();
      repeat (2) @(negedge clk);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule